// File: doc/BRIEF.md
# Subsystem Software Reset Register

This block holds one memory-mapped word whose bits drive the active-low reset lines of on-chip subsystems, one line per bit. Software reaches it over a simple register bus (address, write enable, write data, read data) at a fixed offset. A bit at 0 holds its subsystem in reset; a bit at 1 lets it run. Software asserts or releases one line with a read-modify-write of the whole word, and resets a line fully by clearing its bit and then setting it again.

Two hardware agents share the same bits. A pulse port takes a line index and a start strobe. It clears that bit for a fixed number of clocks and then sets it again without software help. A power-domain sequencer drives a per-bit mask and value, and for the bits it masks it overrides anything else in the same cycle. Reads always return the live register contents, including changes made by the pulse engine or the sequencer.

Top module: `swrst_reg`

## Requirements
- R1: While reset is asserted and right after it, every bit of the register and every reset line is 1, so all subsystems run.
- R2: A bus write with the address equal to REG_OFFSET (default 0x30) loads the whole word. A read at that address returns the register. A read at any other address returns 0, and a write to any other address has no effect.
- R3: Reset line i equals register bit i. A 0 holds the subsystem in reset and a 1 releases it.
- R4: A read-modify-write that clears or sets one bit changes only that line and leaves the other lines as they were.
- R5: A start strobe with no pulse in flight clears the bit selected by the line index at the next edge. The bit stays 0 for exactly PULSE_CYCLES clocks and is then set to 1.
- R6: A start strobe that arrives while a pulse is in flight is ignored. The running pulse keeps its line and its timing.
- R7: Where a sequencer mask bit is 1, the register bit takes the sequencer value at the next edge, overriding a bus write and the pulse engine. Bits with a mask of 0 follow the bus write and the pulse engine.
- R8: Reads return the bits changed by the sequencer and the pulse engine.
- R9: A write that clears a bit, followed by a write that sets it, gives that line a low interval of one clock per cycle between the two writes. All other bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write enable |
| bus_wdata | input | LINES | Register bus write data |
| bus_rdata | output | LINES | Register bus read data (combinational) |
| pulse_start | input | 1 | Start strobe for a self-timed pulse |
| pulse_line | input | $clog2(LINES) | Line index for the pulse |
| seq_mask | input | LINES | Sequencer per-bit override mask |
| seq_value | input | LINES | Sequencer per-bit override value |
| rst_lines_n | output | LINES | Active-low reset lines to subsystems |

## Verification
The hardest case to reach is three agents acting on one bit in the same cycle: a sequencer override on the line that a pulse is holding low, at the moment the pulse expires or a bus write lands. Directed sequences line up a pulse, a bus write and a mask bit on the same line in those cycles. A long random phase then uses sparse pulse strobes, dense bus writes and masks of a few bits each, so that overlaps recur often. A cycle-by-cycle reference model in the bench predicts every line.

// File: rtl/swrst_reg.sv
module swrst_reg #(
  parameter int LINES        = 32,
  parameter int ADDR_W       = 8,
  parameter int REG_OFFSET   = 'h30,
  parameter int PULSE_CYCLES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [LINES-1:0]         bus_wdata,
  output logic [LINES-1:0]         bus_rdata,
  input  logic                     pulse_start,
  input  logic [$clog2(LINES)-1:0] pulse_line,
  input  logic [LINES-1:0]         seq_mask,
  input  logic [LINES-1:0]         seq_value,
  output logic [LINES-1:0]         rst_lines_n
);
  localparam int IDX_W = $clog2(LINES);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic [LINES-1:0] reg_q, reg_d;
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             hit;

  assign hit         = bus_addr == REG_OFFSET[ADDR_W-1:0];
  assign bus_rdata   = hit ? reg_q : '0;
  assign rst_lines_n = reg_q;

  always_comb begin
    reg_d  = (bus_we && hit) ? bus_wdata : reg_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    if (busy_q) begin
      if (cnt_q == '0) begin
        reg_d[sel_q] = 1'b1;
        busy_d       = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end else if (pulse_start) begin
      reg_d[pulse_line] = 1'b0;
      busy_d            = 1'b1;
      cnt_d             = CNT_W'(PULSE_CYCLES - 1);
      sel_d             = pulse_line;
    end
    reg_d = (reg_d & ~seq_mask) | (seq_value & seq_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q  <= '1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
    end else begin
      reg_q  <= reg_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/swrst_reg_chk.sv
module swrst_reg_chk #(
  parameter int LINES      = 32,
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 'h30,
  parameter int CNT_W      = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_we,
  input logic                     pulse_start,
  input logic [$clog2(LINES)-1:0] pulse_line,
  input logic [LINES-1:0]         seq_mask,
  input logic [LINES-1:0]         seq_value,
  input logic [LINES-1:0]         rst_lines_n,
  input logic                     busy_q,
  input logic [CNT_W-1:0]         cnt_q,
  input logic [$clog2(LINES)-1:0] sel_q
);
  logic wr_hit;
  assign wr_hit = bus_we && (bus_addr == REG_OFFSET[ADDR_W-1:0]);

  a_r7_seq_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mask != '0) |=> ((rst_lines_n & $past(seq_mask)) == ($past(seq_value) & $past(seq_mask))));

  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !pulse_start && !busy_q && seq_mask == '0) |=> $stable(rst_lines_n));

  a_r5_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_start && !busy_q && !seq_mask[pulse_line]) |=> !rst_lines_n[$past(pulse_line)]);

  a_r5_pulse_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0 && !seq_mask[sel_q]) |=> rst_lines_n[$past(sel_q)]);
endmodule

bind swrst_reg swrst_reg_chk #(
  .LINES(LINES), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .pulse_start(pulse_start), .pulse_line(pulse_line),
  .seq_mask(seq_mask), .seq_value(seq_value), .rst_lines_n(rst_lines_n),
  .busy_q(busy_q), .cnt_q(cnt_q), .sel_q(sel_q)
);

// File: tb/swrst_reg_tb_top.sv
`timescale 1ns/100ps
module swrst_reg_tb_top;
  localparam int LINES = 32;
  localparam int ADDR_W = 8;
  localparam logic [7:0] OFF = 8'h30;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [LINES-1:0] bus_wdata = '0;
  logic [LINES-1:0] bus_rdata;
  logic pulse_start = 1'b0;
  logic [4:0] pulse_line = '0;
  logic [LINES-1:0] seq_mask = '0;
  logic [LINES-1:0] seq_value = '0;
  logic [LINES-1:0] rst_lines_n;

  int n_checks = 0;
  int n_fail = 0;

  logic [LINES-1:0] m_reg = '1;
  logic m_busy = 1'b0;
  int m_cnt = 0;
  int m_sel = 0;

  always #2.5 clk = ~clk;

  swrst_reg #(.LINES(LINES), .ADDR_W(ADDR_W), .REG_OFFSET('h30), .PULSE_CYCLES(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pulse_start(pulse_start),
    .pulse_line(pulse_line), .seq_mask(seq_mask), .seq_value(seq_value),
    .rst_lines_n(rst_lines_n));

  task automatic check(string tag, logic [LINES-1:0] act, logic [LINES-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [LINES-1:0] exp_read(logic [ADDR_W-1:0] a, logic [LINES-1:0] r);
    return (a == OFF) ? r : '0;
  endfunction

  task automatic model_step();
    logic [LINES-1:0] n;
    n = (bus_we && bus_addr == OFF) ? bus_wdata : m_reg;
    if (m_busy) begin
      if (m_cnt == 0) begin n[m_sel] = 1'b1; m_busy = 1'b0; end
      else m_cnt--;
    end else if (pulse_start) begin
      n[pulse_line] = 1'b0; m_busy = 1'b1; m_cnt = P - 1; m_sel = int'(pulse_line);
    end
    m_reg = (n & ~seq_mask) | (seq_value & seq_mask);
  endtask

  task automatic cyc(string tag, logic [7:0] a, logic we, logic [LINES-1:0] wd,
                     logic ps, logic [4:0] pl, logic [LINES-1:0] sm, logic [LINES-1:0] sv);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd;
    pulse_start = ps; pulse_line = pl; seq_mask = sm; seq_value = sv;
    @(posedge clk);
    model_step();
    #1;
    check(tag, rst_lines_n, m_reg);
    check("R8", bus_rdata, exp_read(bus_addr, m_reg));
  endtask

  task automatic idle(string tag);
    cyc(tag, OFF, 1'b0, '0, 1'b0, '0, '0, '0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [LINES-1:0] v;
    int low;
    bus_addr = OFF;
    #12;
    check("R1", rst_lines_n, '1);
    check("R1", bus_rdata, '1);
    @(negedge clk); rst_n = 1'b1;
    idle("R1");
    check("R1", rst_lines_n, '1);

    // R2: write at offset, other address ignored and reads 0
    cyc("R2", OFF, 1'b1, 32'hA5A5_0F0F, 1'b0, '0, '0, '0);
    check("R3", rst_lines_n, 32'hA5A5_0F0F);
    cyc("R2", 8'h34, 1'b1, 32'h0, 1'b0, '0, '0, '0);
    check("R2", rst_lines_n, 32'hA5A5_0F0F);
    check("R2", bus_rdata, '0);

    // R4: read-modify-write clears then sets bit 9 only
    v = bus_rdata;
    idle("R4"); v = bus_rdata;
    cyc("R4", OFF, 1'b1, v & ~(32'h1 << 9), 1'b0, '0, '0, '0);
    check("R4", rst_lines_n, 32'hA5A5_0D0F);
    cyc("R4", OFF, 1'b1, rst_lines_n | (32'h1 << 9), 1'b0, '0, '0, '0);
    check("R9", rst_lines_n, 32'hA5A5_0F0F);

    // R5: pulse on line 0, count low cycles
    cyc("R2", OFF, 1'b1, '1, 1'b0, '0, '0, '0);
    cyc("R5", OFF, 1'b0, '0, 1'b1, 5'd0, '0, '0);
    low = 0;
    while (!rst_lines_n[0] && low < 20) begin low++; idle("R5"); end
    check("R5", 32'(low), 32'(P));
    check("R5", rst_lines_n, '1);

    // R6: second strobe during pulse ignored
    cyc("R6", OFF, 1'b0, '0, 1'b1, 5'd3, '0, '0);
    cyc("R6", OFF, 1'b0, '0, 1'b1, 5'd7, '0, '0);
    check("R6", rst_lines_n, ~(32'h1 << 3));
    idle("R6"); idle("R6"); idle("R6");
    check("R6", rst_lines_n, '1);

    // R7: sequencer beats bus and pulse on same line
    cyc("R7", OFF, 1'b1, 32'h0, 1'b0, '0, 32'h0000_00F0, 32'h0000_00A0);
    check("R7", rst_lines_n, 32'h0000_00A0);
    cyc("R2", OFF, 1'b1, '1, 1'b0, '0, '0, '0);
    cyc("R7", OFF, 1'b0, '0, 1'b1, 5'd31, 32'h8000_0000, 32'h8000_0000);
    check("R7", rst_lines_n, '1);
    idle("R7"); idle("R7");
    cyc("R7", OFF, 1'b1, 32'h7FFF_FFFF, 1'b0, '0, 32'h8000_0000, 32'h0);
    check("R7", rst_lines_n, 32'h7FFF_FFFF);
    idle("R7");
    cyc("R2", OFF, 1'b1, '1, 1'b0, '0, '0, '0);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [LINES-1:0] sm;
      sm = '0;
      if ($urandom_range(0, 3) == 0) sm[$urandom_range(0, 31)] = 1'b1;
      if ($urandom_range(0, 7) == 0) sm[$urandom_range(0, 31)] = 1'b1;
      cyc("R7", ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : OFF,
          $urandom_range(0, 4) == 0, $urandom(),
          $urandom_range(0, 5) == 0, 5'($urandom_range(0, 31)), sm, $urandom());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule